// File: doc/BRIEF.md
# Chained Command Descriptor DMA Engine

This block is a single-channel DMA engine that walks a linked list of command descriptors in a word-addressed memory. Each descriptor names the next descriptor, a control field, a byte count and a buffer address. It can also carry a few inline register words, which the engine writes to a peripheral before it moves any data. Data moves one 32-bit word per beat, either from a peripheral stream into memory or from memory out to a peripheral stream. Some descriptors move no data at all and only program the peripheral.

Software loads the address of the first descriptor and then adds a count to a semaphore. Each descriptor can decrement the semaphore when it finishes. A chained descriptor that finds the semaphore at zero parks the engine until software adds more. So software can queue work ahead of the engine, or let a ring of descriptors run without end. The engine raises single-cycle pulses for completion, halting termination and errors. It can be frozen and resumed, and reset back to idle.

Top module: `cmdchain_dma`

## Requirements
- R1: A descriptor occupies consecutive memory words starting at its address.
  - Word 0 holds the next-descriptor address.
  - Word 1 holds the control field in bits 15:0 and the byte count in bits 31:16.
  - Word 2 holds the buffer word address.
  - Inline register words start at word 3.
- R2: Loading the next-command register alone starts nothing. When the engine is idle, a semaphore write starts a descriptor fetch from the next-command register once the semaphore is nonzero.
- R3: Control bits 15:12 give N, the number of inline words, from 0 to 15. The engine writes the N words, in order, to peripheral register offsets 0 to N-1, before any data beat of the same descriptor.
- R4: Control bits 1:0 select the command code.
  - Code 1 moves stream words into memory.
  - Code 2 moves memory words to the output stream.
  - Codes 0 and 3 move nothing.
  - A transfer takes ceil(count/4) beats, and the buffer address advances by one word per beat.
- R5: When control bit 2 is set, the engine follows the next address after the descriptor. When it is clear, the engine goes idle. A next address that points back to the same descriptor runs without end.
- R6: When a descriptor with control bit 6 completes, the semaphore drops by one. While the semaphore is zero, the engine makes no memory access, and a chained engine waits until software adds to the semaphore.
- R7: A completed descriptor with control bit 3 set gives a completion pulse exactly one cycle long.
- R8: Two conditions give an error pulse and return the engine to idle: an error response from memory, and a byte count above 0xFF00.
- R9: With control bit 7 set, a descriptor completes only after the peripheral signals end of command.
- R10: A terminate request can arrive during a transfer or an end wait.
  - With control bit 9 set, termination skips the remaining beats.
  - With control bit 8 set, the descriptor ends with a termination pulse and the engine goes idle.
  - With control bit 8 clear, the chain continues.
- R11: While freeze is high, the engine makes no memory, register or stream activity and gives no pulse. Once freeze is released, it resumes where it stopped.
- R12: A channel reset returns the engine to idle and clears the semaphore.
- R13: The current buffer output always shows the word address of the next data beat. After a transfer, it shows the buffer address plus the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nxt_we | input | 1 | Load the next-command register |
| cfg_nxt_addr | input | AW | First descriptor word address |
| sem_we | input | 1 | Add sem_wdata to the semaphore (saturating) |
| sem_wdata | input | SW | Semaphore increment |
| freeze | input | 1 | Pause the channel while high |
| chan_reset | input | 1 | Return the channel to idle and clear the semaphore |
| busy | output | 1 | Engine not idle |
| sem_cnt | output | SW | Semaphore value |
| cur_buf | output | AW | Current buffer word address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Error response, valid with mem_ack |
| pio_we | output | 1 | Peripheral register write |
| pio_addr | output | 4 | Peripheral register offset |
| pio_wdata | output | 32 | Peripheral register data |
| in_valid | input | 1 | Stream word available for memory |
| in_data | input | 32 | Stream word into memory |
| in_ready | output | 1 | Stream word accepted |
| out_valid | output | 1 | Stream word from memory |
| out_data | output | 32 | Stream word to peripheral |
| out_ready | input | 1 | Peripheral can accept a word |
| dev_end | input | 1 | Peripheral end of command |
| dev_term | input | 1 | Peripheral terminate request |
| cmpl_pulse | output | 1 | Descriptor completion |
| term_pulse | output | 1 | Halting termination |
| err_pulse | output | 1 | Bus or length error |

## Verification
A wrong internal state in this engine shows up at the ports within a few cycles. A corrupted word index puts inline words at the wrong peripheral offsets, or sends a stray fetch address on the memory port in the next cycle. A beat counter that drifts shows at the end of the descriptor: the number of stream beats is wrong, and the current buffer address no longer equals the start plus the beat count. Faults in the semaphore or state logic appear as memory requests while the semaphore reads zero, or as missing or extra completion pulses. They can also show as an engine that stays busy, or goes idle, when the chain bits say otherwise.

// File: rtl/cmdchain_pkg.sv
package cmdchain_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned PIO_AW   = 4;
    localparam int unsigned HDR_LAST = 2;
    localparam logic [15:0] MAX_BYTES = 16'hFF00;

    typedef enum logic [1:0] {
        OP_NONE     = 2'd0,
        OP_TO_MEM   = 2'd1,
        OP_FROM_MEM = 2'd2,
        OP_RSVD     = 2'd3
    } op_e;

    typedef struct packed {
        logic [3:0] pio_n;
        logic       flush;
        logic       halt;
        logic       wait_end;
        logic       dec_sem;
        logic       irq;
        logic       chain;
        op_e        op;
    } ctrl_t;

    typedef enum logic [2:0] {
        S_IDLE, S_NEXT, S_HDR, S_PIO, S_XFER, S_WEND, S_DONE
    } state_e;

    function automatic ctrl_t unpack_ctrl(input logic [15:0] f);
        ctrl_t c;
        c.op       = op_e'(f[1:0]);
        c.chain    = f[2];
        c.irq      = f[3];
        c.dec_sem  = f[6];
        c.wait_end = f[7];
        c.halt     = f[8];
        c.flush    = f[9];
        c.pio_n    = f[15:12];
        return c;
    endfunction

    function automatic logic [15:0] beats_of(input logic [15:0] nbytes);
        logic [16:0] t;
        t = {1'b0, nbytes} + 17'd3;
        return {1'b0, t[16:2]};
    endfunction

endpackage

// File: rtl/cmdchain_sem.sv
module cmdchain_sem #(
    parameter int unsigned SW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          add_en,
    input  logic [SW-1:0] add_val,
    input  logic          dec,
    output logic [SW-1:0] count,
    output logic          zero
);
    logic [SW:0]   sum;
    logic [SW-1:0] capped;

    always_comb begin
        sum    = {1'b0, count} + {1'b0, (add_en ? add_val : {SW{1'b0}})};
        capped = sum[SW] ? {SW{1'b1}} : sum[SW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (dec && capped != '0)
            count <= capped - SW'(1);
        else
            count <= capped;
    end

    assign zero = (count == '0);
endmodule

// File: rtl/cmdchain_xfer.sv
module cmdchain_xfer #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [15:0]   load_beats,
    input  logic          step,
    input  logic          kill,
    output logic [AW-1:0] buf_addr,
    output logic          left_zero
);
    logic [15:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_addr <= '0;
            left     <= '0;
        end else if (load) begin
            buf_addr <= load_addr;
            left     <= load_beats;
        end else begin
            if (step)
                buf_addr <= buf_addr + AW'(1);
            if (kill)
                left <= '0;
            else if (step)
                left <= left - 16'd1;
        end
    end

    assign left_zero = (left == 16'd0);
endmodule

// File: rtl/cmdchain_fsm.sv
module cmdchain_fsm
    import cmdchain_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                chan_reset,
    input  logic                freeze,
    input  logic                cfg_nxt_we,
    input  logic [AW-1:0]       cfg_nxt_addr,
    input  logic                sem_we,
    input  logic                sem_zero,
    output logic                sem_dec,
    input  logic [AW-1:0]       buf_addr,
    input  logic                left_zero,
    output logic                x_load,
    output logic [AW-1:0]       x_addr,
    output logic [15:0]         x_beats,
    output logic                x_step,
    output logic                x_kill,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  logic                mem_ack,
    input  logic                mem_err,
    output logic                pio_we,
    output logic [PIO_AW-1:0]   pio_addr,
    output logic [WORD_W-1:0]   pio_wdata,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_data,
    output logic                in_ready,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_data,
    input  logic                out_ready,
    input  logic                dev_end,
    input  logic                dev_term,
    output logic                busy,
    output logic                cmpl_pulse,
    output logic                term_pulse,
    output logic                err_pulse
);
    state_e        state;
    logic [AW-1:0] desc_addr, next_ptr, nxt_cmd;
    logic [3:0]    idx;
    ctrl_t         ctrl;
    logic [15:0]   nbytes;
    logic          term_seen;

    logic run, moving, got, bad_len, term_hit, done;

    assign run    = !freeze;
    assign moving = (state == S_XFER) && !left_zero &&
                    (ctrl.op == OP_TO_MEM || ctrl.op == OP_FROM_MEM);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = buf_addr;
        mem_wdata = in_data;
        unique case (state)
            S_HDR: begin
                mem_req  = run;
                mem_addr = desc_addr + AW'(idx);
            end
            S_PIO: begin
                mem_req  = run;
                mem_addr = desc_addr + AW'(HDR_LAST + 1) + AW'(idx);
            end
            S_XFER: begin
                if (moving) begin
                    if (ctrl.op == OP_TO_MEM) begin
                        mem_req = run && in_valid;
                        mem_we  = 1'b1;
                    end else begin
                        mem_req = run && out_ready;
                    end
                end
            end
            default: ;
        endcase
    end

    assign got      = mem_req && mem_ack && !mem_err;
    assign bad_len  = (state == S_HDR) && (idx == 4'(HDR_LAST)) && (nbytes > MAX_BYTES);
    assign err_pulse = (mem_req && mem_ack && mem_err) || (got && bad_len);

    assign pio_we    = got && (state == S_PIO);
    assign pio_addr  = idx;
    assign pio_wdata = mem_rdata;

    assign in_ready  = got && (state == S_XFER) && mem_we;
    assign out_valid = got && (state == S_XFER) && !mem_we;
    assign out_data  = mem_rdata;

    assign x_step  = got && (state == S_XFER);
    assign x_load  = got && (state == S_HDR) && (idx == 4'(HDR_LAST)) && !bad_len;
    assign x_addr  = mem_rdata[AW-1:0];
    assign x_beats = beats_of(nbytes);

    assign term_hit = run && dev_term && (state == S_XFER || state == S_WEND);
    assign x_kill   = term_hit && (state == S_XFER) && ctrl.flush;

    assign done       = run && (state == S_DONE);
    assign cmpl_pulse = done && ctrl.irq;
    assign term_pulse = done && term_seen && ctrl.halt;
    assign sem_dec    = done && ctrl.dec_sem;
    assign busy       = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst)
            nxt_cmd <= '0;
        else if (done)
            nxt_cmd <= next_ptr;
        else if (cfg_nxt_we)
            nxt_cmd <= cfg_nxt_addr;
    end

    always_ff @(posedge clk) begin
        if (rst || chan_reset) begin
            state     <= S_IDLE;
            idx       <= '0;
            term_seen <= 1'b0;
            if (rst) begin
                desc_addr <= '0;
                next_ptr  <= '0;
                nbytes    <= '0;
                ctrl      <= '0;
            end
        end else if (state == S_IDLE) begin
            if (sem_we)
                state <= S_NEXT;
        end else if (run) begin
            if (term_hit)
                term_seen <= 1'b1;
            unique case (state)
                S_NEXT: begin
                    if (!sem_zero) begin
                        state     <= S_HDR;
                        desc_addr <= nxt_cmd;
                        idx       <= '0;
                        term_seen <= 1'b0;
                    end
                end
                S_HDR: begin
                    if (err_pulse) begin
                        state <= S_IDLE;
                    end else if (got) begin
                        if (idx == 4'd0)
                            next_ptr <= mem_rdata[AW-1:0];
                        if (idx == 4'd1) begin
                            ctrl   <= unpack_ctrl(mem_rdata[15:0]);
                            nbytes <= mem_rdata[31:16];
                        end
                        if (idx == 4'(HDR_LAST)) begin
                            idx   <= '0;
                            state <= (ctrl.pio_n != 4'd0) ? S_PIO : S_XFER;
                        end else begin
                            idx <= idx + 4'd1;
                        end
                    end
                end
                S_PIO: begin
                    if (err_pulse) begin
                        state <= S_IDLE;
                    end else if (got) begin
                        if (idx == ctrl.pio_n - 4'd1) begin
                            idx   <= '0;
                            state <= S_XFER;
                        end else begin
                            idx <= idx + 4'd1;
                        end
                    end
                end
                S_XFER: begin
                    if (err_pulse)
                        state <= S_IDLE;
                    else if (!moving)
                        state <= ctrl.wait_end ? S_WEND : S_DONE;
                end
                S_WEND: begin
                    if (dev_end || dev_term)
                        state <= S_DONE;
                end
                S_DONE: begin
                    if (term_seen && ctrl.halt)
                        state <= S_IDLE;
                    else if (ctrl.chain)
                        state <= S_NEXT;
                    else
                        state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmdchain_dma.sv
module cmdchain_dma
    import cmdchain_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned SW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_nxt_we,
    input  logic [AW-1:0]       cfg_nxt_addr,
    input  logic                sem_we,
    input  logic [SW-1:0]       sem_wdata,
    input  logic                freeze,
    input  logic                chan_reset,
    output logic                busy,
    output logic [SW-1:0]       sem_cnt,
    output logic [AW-1:0]       cur_buf,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  logic                mem_ack,
    input  logic                mem_err,
    output logic                pio_we,
    output logic [PIO_AW-1:0]   pio_addr,
    output logic [WORD_W-1:0]   pio_wdata,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_data,
    output logic                in_ready,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_data,
    input  logic                out_ready,
    input  logic                dev_end,
    input  logic                dev_term,
    output logic                cmpl_pulse,
    output logic                term_pulse,
    output logic                err_pulse
);
    logic          sem_zero, sem_dec;
    logic          left_zero, x_load, x_step, x_kill;
    logic [AW-1:0] x_addr;
    logic [15:0]   x_beats;

    cmdchain_sem #(.SW(SW)) u_sem (
        .clk     (clk),
        .rst     (rst),
        .clr     (chan_reset),
        .add_en  (sem_we),
        .add_val (sem_wdata),
        .dec     (sem_dec),
        .count   (sem_cnt),
        .zero    (sem_zero)
    );

    cmdchain_xfer #(.AW(AW)) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .load       (x_load),
        .load_addr  (x_addr),
        .load_beats (x_beats),
        .step       (x_step),
        .kill       (x_kill),
        .buf_addr   (cur_buf),
        .left_zero  (left_zero)
    );

    cmdchain_fsm #(.AW(AW)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .chan_reset   (chan_reset),
        .freeze       (freeze),
        .cfg_nxt_we   (cfg_nxt_we),
        .cfg_nxt_addr (cfg_nxt_addr),
        .sem_we       (sem_we),
        .sem_zero     (sem_zero),
        .sem_dec      (sem_dec),
        .buf_addr     (cur_buf),
        .left_zero    (left_zero),
        .x_load       (x_load),
        .x_addr       (x_addr),
        .x_beats      (x_beats),
        .x_step       (x_step),
        .x_kill       (x_kill),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .mem_ack      (mem_ack),
        .mem_err      (mem_err),
        .pio_we       (pio_we),
        .pio_addr     (pio_addr),
        .pio_wdata    (pio_wdata),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_ready    (out_ready),
        .dev_end      (dev_end),
        .dev_term     (dev_term),
        .busy         (busy),
        .cmpl_pulse   (cmpl_pulse),
        .term_pulse   (term_pulse),
        .err_pulse    (err_pulse)
    );
endmodule

// File: rtl/cmdchain_dma_chk.sv
module cmdchain_dma_chk #(
    parameter int unsigned AW = 16,
    parameter int unsigned SW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          freeze,
    input logic          chan_reset,
    input logic          busy,
    input logic [SW-1:0] sem_cnt,
    input logic [AW-1:0] cur_buf,
    input logic          mem_req,
    input logic          pio_we,
    input logic          in_ready,
    input logic          out_valid,
    input logic          cmpl_pulse,
    input logic          err_pulse
);
    a_r11_freeze_quiet: assert property (@(posedge clk) disable iff (rst)
        freeze |-> !mem_req && !pio_we && !in_ready && !out_valid && !cmpl_pulse);

    a_r13_buf_held_frozen: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(cur_buf));

    a_r6_no_access_empty_sem: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> sem_cnt != '0);

    a_r8_err_to_idle: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> !busy);

    a_r7_cmpl_one_cycle: assert property (@(posedge clk) disable iff (rst)
        cmpl_pulse |=> !cmpl_pulse);

    a_r12_reset_idle: assert property (@(posedge clk) disable iff (rst)
        chan_reset |=> !busy && sem_cnt == '0);
endmodule

bind cmdchain_dma cmdchain_dma_chk #(.AW(AW), .SW(SW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .freeze     (freeze),
    .chan_reset (chan_reset),
    .busy       (busy),
    .sem_cnt    (sem_cnt),
    .cur_buf    (cur_buf),
    .mem_req    (mem_req),
    .pio_we     (pio_we),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .cmpl_pulse (cmpl_pulse),
    .err_pulse  (err_pulse)
);

// File: tb/test_cmdchain_dma.sv
module test_cmdchain_dma;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int SW = 8;
    localparam logic [15:0] C_CHAIN = 16'h0004, C_IRQ = 16'h0008, C_DEC = 16'h0040,
                            C_WEND = 16'h0080, C_HALT = 16'h0100, C_FLUSH = 16'h0200;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_nxt_we = 0, sem_we = 0, freeze = 0, chan_reset = 0;
    logic [AW-1:0] cfg_nxt_addr = '0;
    logic [SW-1:0] sem_wdata = '0;
    logic busy, mem_req, mem_we, mem_ack, mem_err, pio_we, in_ready, out_valid;
    logic cmpl_pulse, term_pulse, err_pulse;
    logic in_valid = 0, out_ready = 1, dev_end = 0, dev_term = 0;
    logic [SW-1:0] sem_cnt;
    logic [AW-1:0] cur_buf, mem_addr;
    logic [31:0] mem_wdata, mem_rdata, pio_wdata, out_data;
    logic [31:0] in_word = 32'h0000_5000;
    logic [3:0] pio_addr;
    logic [31:0] mem [256];

    int checks = 0, fails = 0, cyc = 0;
    int n_pio = 0, n_out = 0, n_wr = 0, n_cmpl = 0, n_term = 0, n_err = 0;
    logic [3:0]  pio_a [64];
    logic [31:0] pio_d [64], out_d [64], wr_a [64], wr_d [64];
    int pio_c [64], out_c [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_ack   = mem_req;
    assign mem_err   = mem_req && (mem_addr >= 16'h00F0);
    assign mem_rdata = mem[mem_addr[7:0]];

    cmdchain_dma #(.AW(AW), .SW(SW)) i_cmdchain_dma (
        .clk(clk), .rst(rst), .cfg_nxt_we(cfg_nxt_we), .cfg_nxt_addr(cfg_nxt_addr),
        .sem_we(sem_we), .sem_wdata(sem_wdata), .freeze(freeze), .chan_reset(chan_reset),
        .busy(busy), .sem_cnt(sem_cnt), .cur_buf(cur_buf),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .pio_we(pio_we), .pio_addr(pio_addr), .pio_wdata(pio_wdata),
        .in_valid(in_valid), .in_data(in_word), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .dev_end(dev_end), .dev_term(dev_term),
        .cmpl_pulse(cmpl_pulse), .term_pulse(term_pulse), .err_pulse(err_pulse)
    );

    always @(posedge clk) begin
        cyc++;
        if (in_ready) in_word <= in_word + 32'd1;
    end

    always @(negedge clk) begin
        if (pio_we && n_pio < 64) begin
            pio_a[n_pio] = pio_addr; pio_d[n_pio] = pio_wdata; pio_c[n_pio] = cyc; n_pio++;
        end
        if (out_valid && n_out < 64) begin
            out_d[n_out] = out_data; out_c[n_out] = cyc; n_out++;
        end
        if (mem_req && mem_we && !mem_err && n_wr < 64) begin
            wr_a[n_wr] = 32'(mem_addr); wr_d[n_wr] = mem_wdata; n_wr++;
        end
        if (cmpl_pulse) n_cmpl++;
        if (term_pulse) n_term++;
        if (err_pulse)  n_err++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic put_desc(input int base, input int nxt, input logic [15:0] ctl,
                            input logic [15:0] nbytes, input int bufa, input int npio);
        mem[base]     = 32'(nxt);
        mem[base + 1] = {nbytes, ctl | (16'(npio) << 12)};
        mem[base + 2] = 32'(bufa);
        for (int i = 0; i < npio; i++) mem[base + 3 + i] = 32'hA0 + 32'(i);
    endtask

    task automatic set_nxt(input int a);
        tick(1); cfg_nxt_we = 1; cfg_nxt_addr = AW'(a);
        tick(1); cfg_nxt_we = 0;
    endtask

    task automatic give_sem(input int v);
        tick(1); sem_we = 1; sem_wdata = SW'(v);
        tick(1); sem_we = 0;
    endtask

    task automatic chan_rst();
        tick(1); chan_reset = 1;
        tick(1); chan_reset = 0;
    endtask

    task automatic wait_idle(input string req);
        int k = 0;
        while (busy && k < 2000) begin @(negedge clk); k++; end
        chk(!busy, req, 32'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        report();
        $finish;
    end

    initial begin
        int b0, b1, b2, b3, b4, b5;
        logic [AW-1:0] bsave;
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
        tick(3); rst = 0; tick(1);
        @(negedge clk);
        // reset state (R12)
        chk(!busy && sem_cnt == 0, "R12 reset idle", {busy, 24'd0, sem_cnt}, 0);
        chk(!cmpl_pulse && !pio_we && !mem_req, "R12 reset outputs", 32'(mem_req), 0);

        // R1 R2 R3 R6 R7: no-data descriptor with three inline words
        put_desc(0, 0, C_IRQ | C_DEC, 16'd0, 0, 3);
        b0 = n_pio; b1 = n_cmpl;
        set_nxt(0); tick(5); @(negedge clk);
        chk(!busy, "R2 no start without semaphore", 32'(busy), 0);
        give_sem(1); wait_idle("R2 run ends");
        chk(n_pio - b0 == 3, "R3 inline word count", 32'(n_pio - b0), 3);
        for (int i = 0; i < 3; i++)
            chk(pio_a[b0 + i] == 4'(i) && pio_d[b0 + i] == 32'hA0 + 32'(i), "R3 inline word order",
                pio_d[b0 + i], 32'hA0 + 32'(i));
        chk(n_cmpl - b1 == 1, "R7 completion pulse", 32'(n_cmpl - b1), 1);
        chk(sem_cnt == 0, "R6 semaphore decrement", 32'(sem_cnt), 0);

        // R4 R13 R3: memory to stream, 10 bytes = 3 beats
        put_desc(16, 0, 16'h0002 | C_IRQ | C_DEC, 16'd10, 100, 1);
        for (int i = 0; i < 4; i++) mem[100 + i] = 32'h1111_0000 + 32'(i);
        b0 = n_out; b1 = n_pio;
        set_nxt(16); give_sem(1); wait_idle("R4 read run");
        chk(n_out - b0 == 3, "R4 beat count ceil(10/4)", 32'(n_out - b0), 3);
        for (int i = 0; i < 3; i++)
            chk(out_d[b0 + i] == 32'h1111_0000 + 32'(i), "R4 stream data", out_d[b0 + i], 32'h1111_0000 + 32'(i));
        chk(pio_c[b1] < out_c[b0], "R3 inline before data", 32'(pio_c[b1]), 32'(out_c[b0]));
        chk(cur_buf == 16'd103, "R13 buffer address after run", 32'(cur_buf), 103);

        // R4: stream to memory, 8 bytes = 2 beats
        put_desc(32, 0, 16'h0001 | C_IRQ | C_DEC, 16'd8, 120, 0);
        b0 = n_wr; b2 = int'(in_word);
        in_valid = 1;
        set_nxt(32); give_sem(1); wait_idle("R4 write run");
        in_valid = 0;
        chk(n_wr - b0 == 2, "R4 write beats", 32'(n_wr - b0), 2);
        for (int i = 0; i < 2; i++)
            chk(wr_a[b0 + i] == 32'(120 + i) && wr_d[b0 + i] == 32'(b2 + i), "R4 write data",
                wr_d[b0 + i], 32'(b2 + i));

        // R5 R6: chain waits on empty semaphore
        put_desc(40, 48, C_CHAIN | C_IRQ | C_DEC, 16'd0, 0, 0);
        put_desc(48, 0, C_IRQ | C_DEC, 16'd0, 0, 0);
        b1 = n_cmpl;
        set_nxt(40); give_sem(1); tick(15); @(negedge clk);
        chk(busy && n_cmpl - b1 == 1 && sem_cnt == 0, "R6 chain parked", 32'(n_cmpl - b1), 1);
        give_sem(1); wait_idle("R5 chain end");
        chk(n_cmpl - b1 == 2, "R5 second descriptor", 32'(n_cmpl - b1), 2);

        // R5 ring, then R12 reset
        put_desc(64, 64, C_CHAIN | C_IRQ, 16'd0, 0, 0);
        b1 = n_cmpl;
        set_nxt(64); give_sem(1); tick(60); @(negedge clk);
        chk(busy && n_cmpl - b1 >= 3, "R5 ring keeps running", 32'(n_cmpl - b1), 3);
        chan_rst(); @(negedge clk);
        chk(!busy && sem_cnt == 0, "R12 channel reset", {busy, 24'd0, sem_cnt}, 0);

        // R8: bus error, then length error
        b3 = n_err; b1 = n_cmpl;
        set_nxt(245); give_sem(1); wait_idle("R8 bus error idle");
        chk(n_err - b3 == 1 && n_cmpl == b1, "R8 bus error pulse", 32'(n_err - b3), 1);
        chan_rst();
        put_desc(72, 0, 16'h0002 | C_IRQ | C_DEC, 16'hFF01, 100, 0);
        b0 = n_out; b3 = n_err;
        set_nxt(72); give_sem(1); wait_idle("R8 length error idle");
        chk(n_err - b3 == 1 && n_out == b0, "R8 length over 0xFF00", 32'(n_out - b0), 0);
        chan_rst();

        // R9: wait for end of command
        put_desc(80, 0, C_IRQ | C_DEC | C_WEND, 16'd0, 0, 0);
        b1 = n_cmpl;
        set_nxt(80); give_sem(1); tick(20); @(negedge clk);
        chk(busy && n_cmpl == b1, "R9 waits for end", 32'(n_cmpl - b1), 0);
        tick(1); dev_end = 1; tick(1); dev_end = 0;
        wait_idle("R9 end seen");
        chk(n_cmpl - b1 == 1, "R9 completes after end", 32'(n_cmpl - b1), 1);

        // R10: halting termination with flush
        put_desc(88, 96, 16'h0001 | C_CHAIN | C_HALT | C_FLUSH | C_DEC, 16'd40, 130, 0);
        put_desc(96, 0, C_IRQ | C_DEC, 16'd0, 0, 0);
        b1 = n_cmpl; b4 = n_term; b0 = n_wr;
        set_nxt(88); give_sem(2); tick(10);
        dev_term = 1; tick(1); dev_term = 0;
        wait_idle("R10 halt idle");
        chk(n_term - b4 == 1 && n_cmpl == b1, "R10 halt pulse no chain", 32'(n_term - b4), 1);
        chk(sem_cnt == 1, "R10 semaphore after halt", 32'(sem_cnt), 1);
        // R10: termination without halt continues the chain
        put_desc(104, 96, 16'h0001 | C_CHAIN | C_FLUSH, 16'd40, 130, 0);
        b4 = n_term;
        set_nxt(104); give_sem(0); tick(10);
        dev_term = 1; tick(1); dev_term = 0;
        wait_idle("R10 continue idle");
        chk(n_cmpl - b1 == 1 && n_term == b4 && n_wr == b0, "R10 chain continues", 32'(n_cmpl - b1), 1);
        chan_rst();

        // R11: freeze holds everything
        put_desc(112, 0, 16'h0002 | C_IRQ | C_DEC, 16'd16, 100, 0);
        b0 = n_out; b5 = n_pio; bsave = cur_buf;
        freeze = 1;
        set_nxt(112); give_sem(1); tick(10); @(negedge clk);
        chk(busy && n_out == b0 && n_pio == b5 && cur_buf == bsave, "R11 frozen quiet",
            32'(n_out - b0), 0);
        tick(1); freeze = 0;
        wait_idle("R11 resumes");
        chk(n_out - b0 == 4 && out_d[b0 + 3] == 32'h1111_0003, "R11 resumed beats", 32'(n_out - b0), 4);
        chk(cur_buf == 16'd104, "R13 buffer after resume", 32'(cur_buf), 104);

        report();
        $finish;
    end
endmodule